// File: doc/BRIEF.md
# CAN Bit Timing Segment Generator

This block derives the bit timing of a CAN node from the system clock. A programmable prescaler divides the clock into time quanta. A segment sequencer then steps through each bit: a one-quantum synchronisation segment, a first timing segment (propagation plus phase 1), and a second timing segment (phase 2). It emits a one-clock strobe at the sample point and a one-clock strobe that marks the start of every bit. A receive-side controller uses these strobes to latch the bus value and to advance its bit counter. Frame decoding, stuffing and error handling stay outside.

The receive line is examined once per quantum. A falling transition is a recessive (1) to dominant (0) change between two consecutive quanta. When the controller asserts the hard-synchronisation enable, such an edge restarts the bit at once. Otherwise the edge resynchronises the bit: the first timing segment is stretched, or the second is cut short, by the phase error, limited to the jump width. All four timing values come from one packed configuration word in which each field holds its value minus one.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word holds four fields, each storing its value minus one: prescaler in bits [9:0], segment 1 in [19:16], segment 2 in [22:20], jump width in [25:24]. With no edges on the receive line, consecutive `bit_start_stb` pulses are prescaler*(1+seg1+seg2) clocks apart. For example, word 0x0023000B gives 12*(1+4+3) = 96 clocks.
- R2: `tq_stb` pulses once every prescaler clocks.
- R3: `sample_stb` pulses prescaler*seg1 clocks after `bit_start_stb`, at most once per bit.
- R4: Every strobe is one clock wide. `sample_stb` and `bit_start_stb` never occur together, and each coincides with a `tq_stb` pulse.
- R5: With hard sync disabled, a falling edge seen in quantum k of the bit (the sync quantum is k=0, segment 1 is quanta 1..seg1) lengthens the bit and delays the sample by min(k, jump width) quanta.
- R6: With hard sync disabled, a falling edge seen in quantum k of segment 2 (N = 1+seg1+seg2, k < N) shortens the bit by min(N-k, jump width) quanta. When N-k is within the jump width, the edge quantum itself becomes the next sync quantum.
- R7: A falling edge seen in the sync quantum leaves the bit length unchanged.
- R8: Only the first falling edge in a bit resynchronises it; a later falling edge in the same bit, and any rising edge, has no effect on timing.
- R9: With hard sync enabled, a falling edge seen in quantum k restarts the bit at that quantum: `bit_start_stb` pulses k quanta after the previous one, regardless of the jump width, and a sample not yet taken in that bit is dropped.
- R10: During reset all strobes are low. After reset the first strobe is `bit_start_stb`, prescaler clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_cfg | input | 32 | Packed timing configuration, fields stored minus one |
| rx_in | input | 1 | Receive line, 1 = recessive, synchronous to clk |
| hsync_en | input | 1 | Falling edges cause hard synchronisation when high |
| tq_stb | output | 1 | One-clock pulse at the end of every time quantum |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| bit_start_stb | output | 1 | One-clock pulse at the end of the sync quantum of every bit |

## Verification
The bench keeps the default field widths and positions, so segment 1 can reach 16 quanta, segment 2 can reach 8 and the jump width can reach 4. The full correction range of R5 and R6 therefore applies, including the cases where the phase error exceeds the jump width. At run time the prescaler is kept between 1 and 4, plus one directed 12-clock case. This keeps a bit within about a hundred clocks, so many randomly chosen edge positions fit into a short run. The extreme prescaler of 1 exercises the strobe timing when a quantum lasts one clock.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } seg_phase_e;

  // phase correction: the error, capped by the jump width
  function automatic int unsigned sjw_clip(input int unsigned err,
                                           input int unsigned sjw);
    return (err < sjw) ? err : sjw;
  endfunction

  // widest of three field widths
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cbt_cfg_decode.sv
module cbt_cfg_decode #(
  parameter int CFG_W   = 32,
  parameter int BRP_W   = 10,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int BRP_LSB = 0,
  parameter int TS1_LSB = 16,
  parameter int TS2_LSB = 20,
  parameter int SJW_LSB = 24,
  parameter int CNT_W   = 6
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [BRP_W-1:0] brp_field,
  output logic [CNT_W-1:0] ts1_len,
  output logic [CNT_W-1:0] ts2_len,
  output logic [CNT_W-1:0] sjw_len
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic unused_cfg_bits;

  // prescaler is kept raw: the divider compares against value-minus-one
  assign brp_field = cfg[BRP_LSB +: BRP_W];
  assign ts1_len   = CNT_W'(cfg[TS1_LSB +: TS1_W]) + ONE;
  assign ts2_len   = CNT_W'(cfg[TS2_LSB +: TS2_W]) + ONE;
  assign sjw_len   = CNT_W'(cfg[SJW_LSB +: SJW_W]) + ONE;

  assign unused_cfg_bits = &{1'b0, cfg};
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_field,
  output logic             tick
);
  logic [BRP_W-1:0] pcnt_q;

  assign tick = (pcnt_q == brp_field);

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else           pcnt_q <= pcnt_q + BRP_W'(1);
  end
endmodule

// File: rtl/cbt_rx_edge.sv
module cbt_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_in,
  output logic fall
);
  logic rx_last_q;

  // recessive in the previous quantum, dominant in this one
  assign fall = tick & rx_last_q & ~rx_in;

  always_ff @(posedge clk) begin
    if (!rst_n)    rx_last_q <= 1'b1;
    else if (tick) rx_last_q <= rx_in;
  end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fall,
  input  logic             hsync_en,
  input  logic [CNT_W-1:0] ts1_len,
  input  logic [CNT_W-1:0] ts2_len,
  input  logic [CNT_W-1:0] sjw_len,
  output logic             tq_stb,
  output logic             sample_stb,
  output logic             bit_start_stb,
  output logic             hard_sync,
  output logic             resync_lengthen,
  output logic             resync_shorten
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seg_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] seg1_q, seg1_d;
  logic [CNT_W-1:0] seg2_q, seg2_d;
  logic [CNT_W-1:0] err;
  logic             resynced_q, resynced_d;
  logic             smp_d, start_d;
  logic             resync_ok;

  assign resync_ok = fall & ~resynced_q & ~hsync_en;

  always_comb begin
    phase_d         = phase_q;
    cnt_d           = cnt_q;
    seg1_d          = seg1_q;
    seg2_d          = seg2_q;
    resynced_d      = resynced_q;
    smp_d           = 1'b0;
    start_d         = 1'b0;
    hard_sync       = 1'b0;
    resync_lengthen = 1'b0;
    resync_shorten  = 1'b0;
    err             = '0;
    if (tick) begin
      if (fall && hsync_en) begin
        // the edge quantum becomes the sync quantum
        hard_sync  = 1'b1;
        start_d    = 1'b1;
        phase_d    = PH_SEG1;
        cnt_d      = '0;
        seg1_d     = ts1_len;
        seg2_d     = ts2_len;
        resynced_d = 1'b1;
      end else begin
        unique case (phase_q)
          PH_SYNC: begin
            start_d    = 1'b1;
            phase_d    = PH_SEG1;
            cnt_d      = '0;
            seg1_d     = ts1_len;
            seg2_d     = ts2_len;
            resynced_d = 1'b0;
          end
          PH_SEG1: begin
            if (resync_ok) begin
              resync_lengthen = 1'b1;
              err             = cnt_q + ONE;
              seg1_d          = seg1_q + CNT_W'(sjw_clip(32'(err), 32'(sjw_len)));
              resynced_d      = 1'b1;
            end
            if (cnt_q == seg1_d - ONE) begin
              smp_d   = 1'b1;
              phase_d = PH_SEG2;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
          PH_SEG2: begin
            if (resync_ok) begin
              resync_shorten = 1'b1;
              err            = seg2_q - cnt_q;
            end
            if (resync_ok && (err <= sjw_len)) begin
              // full correction: this quantum is the next sync
              start_d    = 1'b1;
              phase_d    = PH_SEG1;
              cnt_d      = '0;
              seg1_d     = ts1_len;
              seg2_d     = ts2_len;
              resynced_d = 1'b0;
            end else begin
              if (resync_ok) begin
                seg2_d     = seg2_q - sjw_len;
                resynced_d = 1'b1;
              end
              if (cnt_q == seg2_d - ONE) begin
                phase_d = PH_SYNC;
                cnt_d   = '0;
              end else begin
                cnt_d = cnt_q + ONE;
              end
            end
          end
          default: phase_d = PH_SYNC;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q       <= PH_SYNC;
      cnt_q         <= '0;
      seg1_q        <= ONE;
      seg2_q        <= ONE;
      resynced_q    <= 1'b0;
      tq_stb        <= 1'b0;
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      cnt_q         <= cnt_d;
      seg1_q        <= seg1_d;
      seg2_q        <= seg2_d;
      resynced_q    <= resynced_d;
      tq_stb        <= tick;
      sample_stb    <= smp_d;
      bit_start_stb <= start_d;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int BRP_W   = 10,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int BRP_LSB = 0,
  parameter int TS1_LSB = 16,
  parameter int TS2_LSB = 20,
  parameter int SJW_LSB = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] timing_cfg,
  input  logic             rx_in,
  input  logic             hsync_en,
  output logic             tq_stb,
  output logic             sample_stb,
  output logic             bit_start_stb
);
  // room for a stretched segment 1 (field max plus jump width max)
  localparam int CNT_W = max3(TS1_W, TS2_W, SJW_W) + 2;

  logic [BRP_W-1:0] brp_field;
  logic [CNT_W-1:0] ts1_len, ts2_len, sjw_len;
  logic             tq_tick_w;
  logic             rx_fall_w;
  logic             hard_sync_w;
  logic             lengthen_w;
  logic             shorten_w;

  cbt_cfg_decode #(
    .CFG_W(CFG_W), .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
    .SJW_W(SJW_W), .BRP_LSB(BRP_LSB), .TS1_LSB(TS1_LSB),
    .TS2_LSB(TS2_LSB), .SJW_LSB(SJW_LSB), .CNT_W(CNT_W)
  ) u_decode (
    .cfg(timing_cfg), .brp_field(brp_field),
    .ts1_len(ts1_len), .ts2_len(ts2_len), .sjw_len(sjw_len)
  );

  cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .brp_field(brp_field), .tick(tq_tick_w)
  );

  cbt_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick_w), .rx_in(rx_in), .fall(rx_fall_w)
  );

  cbt_seg_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick_w), .fall(rx_fall_w),
    .hsync_en(hsync_en), .ts1_len(ts1_len), .ts2_len(ts2_len),
    .sjw_len(sjw_len), .tq_stb(tq_stb), .sample_stb(sample_stb),
    .bit_start_stb(bit_start_stb), .hard_sync(hard_sync_w),
    .resync_lengthen(lengthen_w), .resync_shorten(shorten_w)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int BRP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BRP_W-1:0] brp_field,
  input logic             tq_stb,
  input logic             sample_stb,
  input logic             bit_start_stb,
  input logic             hard_sync,
  input logic             resync_lengthen,
  input logic             resync_shorten
);
  logic [BRP_W:0] gap_q;
  logic           seen_tq_q;
  logic           smp_seen_q;
  logic           unused_evt;

  assign unused_evt = resync_shorten;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_tq_q  <= 1'b0;
      smp_seen_q <= 1'b0;
    end else begin
      if (tq_stb) begin
        gap_q     <= (BRP_W+1)'(1);
        seen_tq_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + (BRP_W+1)'(1);
      end
      if (bit_start_stb)   smp_seen_q <= 1'b0;
      else if (sample_stb) smp_seen_q <= 1'b1;
    end
  end

  assert_quantum_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_stb && seen_tq_q) |-> (gap_q == (BRP_W+1)'(brp_field) + (BRP_W+1)'(1)));

  assert_one_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !smp_seen_q);

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start_stb));

  assert_strobe_on_quantum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || bit_start_stb) |-> tq_stb);

  assert_lengthen_delays_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resync_lengthen |=> !sample_stb);

  assert_hard_sync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hard_sync |=> bit_start_stb);
endmodule

bind can_bit_timer can_bit_timer_chk #(.BRP_W(BRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .brp_field(brp_field), .tq_stb(tq_stb),
  .sample_stb(sample_stb), .bit_start_stb(bit_start_stb),
  .hard_sync(hard_sync_w), .resync_lengthen(lengthen_w),
  .resync_shorten(shorten_w)
);

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_cfg = 32'h0;
  logic        rx_in = 1'b1;
  logic        hsync_en = 1'b0;
  logic        tq_stb, sample_stb, bit_start_stb;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;
  int brp_c, ts1_c, ts2_c, sjw_c;

  always #2.5 clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .rx_in(rx_in),
    .hsync_en(hsync_en), .tq_stb(tq_stb), .sample_stb(sample_stb),
    .bit_start_stb(bit_start_stb)
  );

  function automatic logic [31:0] pack_cfg(int brp, int s1, int s2, int sj);
    return 32'((brp - 1) & 32'h3FF) | (32'((s1 - 1) & 15) << 16) |
           (32'((s2 - 1) & 7) << 20) | (32'((sj - 1) & 3) << 24);
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // expected bit length in quanta, for one edge at quantum ek (0 = none)
  function automatic int exp_len(int ek, bit hs);
    int n;
    n = 1 + ts1_c + ts2_c;
    if (ek <= 0 || ek >= n) return n;
    if (hs) return ek;
    if (ek <= ts1_c) return n + min2(ek, sjw_c);
    return n - min2(n - ek, sjw_c);
  endfunction

  // expected sample position in quanta after the bit start, -1 for none
  function automatic int exp_samp(int ek, bit hs);
    int n;
    n = 1 + ts1_c + ts2_c;
    if (ek <= 0 || ek >= n || ek > ts1_c) return ts1_c;
    if (hs) return -1;
    return ts1_c + min2(ek, sjw_c);
  endfunction

  task automatic check_int(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_cfg(logic [31:0] word);
    int cyc;
    timing_cfg = word;
    brp_c = int'(word[9:0]) + 1;
    ts1_c = int'(word[19:16]) + 1;
    ts2_c = int'(word[22:20]) + 1;
    sjw_c = int'(word[25:24]) + 1;
    rst_n = 1'b0;
    rx_in = 1'b1;
    hsync_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10: strobes low while reset is held
    check_int("R10 strobes in reset", int'({tq_stb, sample_stb, bit_start_stb}), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sample_stb || bit_start_stb) break;
    end
    check_int("R10 first strobe is bit start", int'(bit_start_stb), 1);
    check_int("R10 first bit start delay", cyc, brp_c);
  endtask

  // entered just after a bit_start pulse; runs until the next one
  task automatic run_bit(input int ek, input int ek2, input bit hs,
                         output int len, output int samp, output bit tq_ok);
    int cyc, k, last_tq;
    cyc = 0; k = 0; last_tq = 0;
    len = -1; samp = -1; tq_ok = 1'b1;
    hsync_en = hs;
    rx_in = (ek == 1 || ek2 == 1) ? 1'b0 : 1'b1;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sample_stb) samp = cyc;
      if (tq_stb) begin
        if (cyc - last_tq != brp_c) tq_ok = 1'b0;
        last_tq = cyc;
        k++;
      end
      if (bit_start_stb) begin
        len = cyc;
        break;
      end
      if (tq_stb) rx_in = (k + 1 == ek || k + 1 == ek2) ? 1'b0 : 1'b1;
    end
    hsync_en = 1'b0;
  endtask

  task automatic do_bit(int ek, int ek2, bit hs, string tag);
    int len, samp, es;
    bit tq_ok;
    run_bit(ek, ek2, hs, len, samp, tq_ok);
    es = exp_samp(ek, hs);
    check_int({tag, " bit length"}, len, brp_c * exp_len(ek, hs));
    check_int({tag, " sample position"}, samp, (es < 0) ? -1 : brp_c * es);
    check_int("R2 quantum spacing", int'(tq_ok), 1);
  endtask

  initial begin
    int n, ek, ek2;
    bit hs;
    string tag;
    void'($urandom(32'd1234));
    // R1: packed word example, 12 * 8 = 96 clocks, sample at 48
    start_cfg(32'h0023000B);
    do_bit(0, 0, 1'b0, "R1");
    do_bit(0, 0, 1'b0, "R1");
    // R3: 1 + 13 + 2 quanta at one clock per quantum
    start_cfg(pack_cfg(1, 13, 2, 1));
    do_bit(0, 0, 1'b0, "R3");
    // R5 / R6 / R7 / R8 / R9 directed, N = 11, jump width 2
    start_cfg(pack_cfg(2, 6, 4, 2));
    do_bit(1, 0, 1'b0, "R5 lengthen by error");
    do_bit(5, 0, 1'b0, "R5 lengthen capped");
    do_bit(10, 0, 1'b0, "R6 edge becomes sync");
    do_bit(7, 0, 1'b0, "R6 shorten capped");
    do_bit(11, 0, 1'b0, "R7 edge into next sync");
    do_bit(0, 0, 1'b0, "R7 after sync edge");
    do_bit(2, 6, 1'b0, "R8 second edge ignored");
    do_bit(3, 0, 1'b1, "R9 hard sync in seg1");
    do_bit(0, 0, 1'b0, "R8 rising edge ignored");
    do_bit(9, 0, 1'b1, "R9 hard sync in seg2");
    // random configurations and edge positions
    for (int it = 0; it < 40; it++) begin
      start_cfg(pack_cfg(1 + int'($urandom % 4), 1 + int'($urandom % 16),
                         1 + int'($urandom % 8), 1 + int'($urandom % 4)));
      do_bit(0, 0, 1'b0, "R1 random nominal");
      n = 1 + ts1_c + ts2_c;
      ek = 1 + int'($urandom % 32'(n - 1));
      hs = (($urandom % 4) == 0);
      ek2 = 0;
      if (ek + 2 < n && ($urandom % 2) == 1)
        ek2 = ek + 2 + int'($urandom % 32'(n - ek - 2));
      if (hs) tag = "R9 random";
      else if (ek <= ts1_c) tag = "R5 random";
      else tag = "R6 random";
      do_bit(ek, ek2, hs, tag);
      do_bit(0, 0, 1'b0, "R8 random follow-up");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule